// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits in front of a single-port word memory shared by several bus masters and makes load-exclusive / store-exclusive pairs work between them. A load-exclusive returns the addressed word and records, for the issuing master only, the word address it now watches. A later store-exclusive from that master writes its data only if that record is still intact, and reports a one-bit status: 0 means the store landed, 1 means it was dropped.

Any write that commits to memory breaks every record watching that address. This covers a plain write from any master, the watching master included, and a successful store-exclusive. Software builds atomic read-modify-write sequences on top of this by retrying when the status is 1.

Each master has a request channel with valid/ready handshaking. A master holds `req_valid` and its request fields steady until it sees `req_ready` high in the same cycle. One request is accepted per cycle, chosen by fixed priority, and the lowest master index wins. The response comes back exactly one cycle after acceptance as a single-cycle `rsp_valid` pulse. The response channel has no ready signal and cannot be back-pressured.

Top module: `excl_access_monitor`

## Requirements
- R1: A load-exclusive (op code 2'b10) returns the current word at its address on `rsp_rdata` and arms that master's reservation for that address.
- R2: A store-exclusive (op code 2'b11) whose master holds a valid reservation for the same address writes `req_wdata` to memory and responds with `rsp_fail` = 0.
- R3: A store-exclusive issued with no valid reservation, or to an address other than the reserved one, leaves memory unchanged and responds with `rsp_fail` = 1.
- R4: A write committed by another master to a reserved address breaks that reservation. This includes a plain write (op code 2'b01) and a successful store-exclusive. A later store-exclusive there by the reserving master fails.
- R5: A master keeps one reservation. A new load-exclusive from that master replaces the previous one.
- R6: Every store-exclusive clears the issuing master's reservation, whether it succeeds or fails.
- R7: A master's own plain write to its reserved address clears its own reservation.
- R8: When several masters are valid in a cycle, only the lowest-indexed one sees `req_ready` high. `req_ready` is never high for a master whose `req_valid` is low.
- R9: One cycle after a request is accepted, `rsp_valid` pulses for exactly that master. A read (op code 2'b00) returns the stored word. A plain write responds with `rsp_fail` = 0.
- R10: A synchronous active-high `rst` clears all reservations and holds every `req_ready` and `rsp_valid` low.
- R11: A write to a different address does not disturb a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_MASTERS | Request valid, one bit per master |
| req_ready | output | N_MASTERS | Request accepted this cycle |
| req_op | input | 2*N_MASTERS | Operation per master: 00 read, 01 write, 10 load-exclusive, 11 store-exclusive |
| req_addr | input | ADDR_W*N_MASTERS | Word address per master |
| req_wdata | input | DATA_W*N_MASTERS | Write data per master |
| rsp_valid | output | N_MASTERS | Response pulse, one cycle after acceptance |
| rsp_rdata | output | DATA_W*N_MASTERS | Read data per master, meaningful for read and load-exclusive |
| rsp_fail | output | N_MASTERS | Store-exclusive status: 1 means failed, 0 otherwise |

## Verification
Assertions check several properties on every cycle:
- The grant is one-hot or zero and follows strict priority.
- A response follows only an acceptance.
- The store-exclusive status matches the reservation held when the request was accepted.
- A committed write leaves no reservation on its address.
- A store-exclusive leaves its master unreserved.

Other properties only the bench's scenarios can show. These include that a failed store-exclusive truly leaves memory untouched, and that a load-exclusive returns the right word. They also include the cross-master sequences: a break by a foreign write, replacement by a second load-exclusive, a break by the master's own write, survival across unrelated writes, and loss across reset.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_LDEX  = 2'b10,
    OP_STEX  = 2'b11
  } xop_e;
endpackage

// File: rtl/xmon_arbiter.sv
module xmon_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // R8: at most one master served per cycle
  a_r8_one_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  // R8: no grant without a request
  a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (rst) (grant & ~req) == '0);

  // R8: a granted master has no lower-indexed competitor
  for (genvar i = 1; i < N; i++) begin : g_prio
    localparam logic [N-1:0] LOWER = N'((1 << i) - 1);
    a_r8_priority: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> ((req & LOWER) == '0));
  end
endmodule

// File: rtl/xmon_resv.sv
module xmon_resv
  import xmon_pkg::*;
#(
  parameter int N      = 3,
  parameter int ADDR_W = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic [IDX_W-1:0]  sel_idx,
  input  xop_e              sel_op,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic              stex_ok,
  output logic              commit
);
  logic [N-1:0]      res_v;
  logic [ADDR_W-1:0] res_a [N];

  always_comb begin
    stex_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_idx == IDX_W'(i) && res_v[i] && res_a[i] == sel_addr) stex_ok = 1'b1;
    end
  end

  assign commit = sel_valid && (sel_op == OP_WRITE || (sel_op == OP_STEX && stex_ok));

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic mine;
    assign mine = sel_valid && sel_idx == IDX_W'(i);

    always_ff @(posedge clk) begin
      if (rst) begin
        res_v[i] <= 1'b0;
        res_a[i] <= '0;
      end else if (mine && sel_op == OP_LDEX) begin
        res_v[i] <= 1'b1;
        res_a[i] <= sel_addr;
      end else if (mine && sel_op == OP_STEX) begin
        res_v[i] <= 1'b0;
      end else if (commit && res_a[i] == sel_addr) begin
        res_v[i] <= 1'b0;
      end
    end

    // R6: any store-exclusive leaves its master unreserved
    a_r6_stex_clears: assert property (@(posedge clk) disable iff (rst)
      (mine && sel_op == OP_STEX) |=> !res_v[i]);

    // R4/R7: a committed write leaves no reservation on its address
    a_r4_commit_breaks: assert property (@(posedge clk) disable iff (rst)
      (commit && res_v[i] && res_a[i] == sel_addr) |=> !res_v[i]);
  end
endmodule

// File: rtl/xmon_mem.sv
module xmon_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      rdata <= store[addr];
    end
  end
endmodule

// File: rtl/excl_access_monitor.sv
module excl_access_monitor
  import xmon_pkg::*;
#(
  parameter int N_MASTERS = 3,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MASTERS-1:0]        req_valid,
  output logic [N_MASTERS-1:0]        req_ready,
  input  logic [2*N_MASTERS-1:0]      req_op,
  input  logic [ADDR_W*N_MASTERS-1:0] req_addr,
  input  logic [DATA_W*N_MASTERS-1:0] req_wdata,
  output logic [N_MASTERS-1:0]        rsp_valid,
  output logic [DATA_W*N_MASTERS-1:0] rsp_rdata,
  output logic [N_MASTERS-1:0]        rsp_fail
);
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] grant;
  logic                 sel_valid;
  logic [IDX_W-1:0]     sel_idx;
  xop_e                 sel_op;
  logic [ADDR_W-1:0]    sel_addr;
  logic [DATA_W-1:0]    sel_wdata;
  logic                 stex_ok;
  logic                 commit;
  logic [DATA_W-1:0]    mem_rdata;
  logic [N_MASTERS-1:0] rsp_v_q;
  logic                 fail_q;

  xmon_arbiter #(.N(N_MASTERS)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (req_valid),
    .grant (grant)
  );

  assign req_ready = rst ? '0 : grant;
  assign sel_valid = |req_ready;

  always_comb begin
    sel_idx   = '0;
    sel_op    = OP_READ;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (grant[i]) begin
        sel_idx   = IDX_W'(i);
        sel_op    = xop_e'(req_op[i*2 +: 2]);
        sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  xmon_resv #(.N(N_MASTERS), .ADDR_W(ADDR_W)) u_resv (
    .clk       (clk),
    .rst       (rst),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_op    (sel_op),
    .sel_addr  (sel_addr),
    .stex_ok   (stex_ok),
    .commit    (commit)
  );

  xmon_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .en    (sel_valid),
    .we    (commit),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_v_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      rsp_v_q <= req_ready;
      fail_q  <= sel_valid && sel_op == OP_STEX && !stex_ok;
    end
  end

  assign rsp_valid = rsp_v_q;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_rsp
    assign rsp_rdata[i*DATA_W +: DATA_W] = mem_rdata;
    assign rsp_fail[i] = rsp_v_q[i] & fail_q;
  end

  // R2: a store-exclusive holding a matching reservation responds with success
  a_r2_stex_pass: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_op == OP_STEX && commit) |=> (rsp_valid != '0 && rsp_fail == '0));

  // R3: a store-exclusive without a matching reservation reports failure
  a_r3_stex_fail: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_op == OP_STEX && !stex_ok) |=> (rsp_fail == rsp_valid && rsp_valid != '0));

  // R9: no response without an acceptance one cycle earlier
  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> rsp_valid == '0);

  // R10: reset drives the response side idle
  a_r10_reset_idle: assert property (@(posedge clk) rst |=> rsp_valid == '0);
endmodule

// File: tb/excl_access_monitor_test.sv
`timescale 1ns/1ps
module excl_access_monitor_test;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    v = '0;
  logic [2*N-1:0]  op = '0;
  logic [AW*N-1:0] addr = '0;
  logic [DW*N-1:0] wdata = '0;
  logic [N-1:0]    req_ready, rsp_valid, rsp_fail;
  logic [DW*N-1:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  int unsigned mem_m [1 << AW];
  bit rv [N];
  int ra [N];

  always #10 clk = ~clk;

  excl_access_monitor #(.N_MASTERS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(v), .req_ready(req_ready), .req_op(op),
    .req_addr(addr), .req_wdata(wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
  );

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put(int m, logic [1:0] o, int a, int unsigned d);
    v[m] = 1'b1;
    op[m*2 +: 2] = o;
    addr[m*AW +: AW] = AW'(a);
    wdata[m*DW +: DW] = d;
  endtask

  // one clock: check ready now, update model, check response next negedge
  task automatic step();
    int g;
    logic [N-1:0] er, ev, ef;
    logic [1:0] o;
    int a;
    int unsigned d, exp_d;
    bit ok, rd;
    #2;
    g = -1;
    if (!rst) for (int i = 0; i < N; i++) if (v[i] && g < 0) g = i;
    er = (g >= 0) ? N'(1 << g) : '0;
    chk(req_ready == er, "req_ready (R8)", req_ready, er);
    ev = er; ef = '0; rd = 0; exp_d = 0; o = 0;
    if (rst) begin
      for (int i = 0; i < N; i++) rv[i] = 0;
    end else if (g >= 0) begin
      o = op[g*2 +: 2];
      a = int'(addr[g*AW +: AW]);
      d = wdata[g*DW +: DW];
      case (o)
        2'b00: begin rd = 1; exp_d = mem_m[a]; end
        2'b01: begin
          mem_m[a] = d;
          for (int i = 0; i < N; i++) if (ra[i] == a) rv[i] = 0;
        end
        2'b10: begin rd = 1; exp_d = mem_m[a]; rv[g] = 1; ra[g] = a; end
        default: begin
          ok = rv[g] && ra[g] == a;
          rv[g] = 0;
          if (ok) begin
            mem_m[a] = d;
            for (int i = 0; i < N; i++) if (ra[i] == a) rv[i] = 0;
          end else ef = er;
        end
      endcase
    end
    @(negedge clk);
    chk(rsp_valid == ev, "rsp_valid (R9)", rsp_valid, ev);
    chk(rsp_fail == ef, "rsp_fail", rsp_fail, ef);
    if (rd) chk(rsp_rdata[g*DW +: DW] == exp_d, "rsp_rdata (R1/R9)", rsp_rdata[g*DW +: DW], exp_d);
    v = '0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin rv[i] = 0; ra[i] = 0; end
    @(negedge clk);
    // R10: reset holds ready and response low
    tag = "R10";
    put(0, 2'b00, 0, 0); step(); step();
    rst = 1'b0;
    step();
    // fill memory with plain writes, response status 0
    tag = "R9";
    for (int a = 0; a < (1 << AW); a++) begin
      put(a % N, 2'b01, a, 32'h1000_0000 + a * 32'h0101); step();
    end
    put(2, 2'b00, 5, 0); step();
    put(1, 2'b00, 63, 0); step();
    // R1 + R2: load-exclusive then matching store-exclusive succeeds
    tag = "R2";
    put(1, 2'b10, 5, 0); step();
    put(1, 2'b11, 5, 32'hCAFE_0005); step();
    put(0, 2'b00, 5, 0); step();
    // R6: a second store-exclusive after success fails
    tag = "R6";
    put(1, 2'b11, 5, 32'hDEAD_0005); step();
    put(0, 2'b00, 5, 0); step();
    // R3: no reservation, and wrong address
    tag = "R3";
    put(2, 2'b11, 7, 32'h1111_1111); step();
    put(2, 2'b10, 7, 0); step();
    put(2, 2'b11, 8, 32'h2222_2222); step();
    put(2, 2'b00, 8, 0); step();
    put(2, 2'b11, 7, 32'h3333_3333); step();
    // R4: another master's plain write breaks the reservation
    tag = "R4";
    put(0, 2'b10, 9, 0); step();
    put(2, 2'b01, 9, 32'h4444_0009); step();
    put(0, 2'b11, 9, 32'h5555_0009); step();
    put(0, 2'b00, 9, 0); step();
    // R4: a successful store-exclusive breaks another master's reservation
    put(0, 2'b10, 10, 0); step();
    put(1, 2'b10, 10, 0); step();
    put(0, 2'b11, 10, 32'hAAAA_000A); step();
    put(1, 2'b11, 10, 32'hBBBB_000A); step();
    put(1, 2'b00, 10, 0); step();
    // R5: a newer load-exclusive replaces the older reservation
    tag = "R5";
    put(1, 2'b10, 11, 0); step();
    put(1, 2'b10, 12, 0); step();
    put(1, 2'b11, 11, 32'h6666_000B); step();
    put(1, 2'b10, 11, 0); step();
    put(1, 2'b10, 12, 0); step();
    put(1, 2'b11, 12, 32'h7777_000C); step();
    // R7: own plain write clears own reservation
    tag = "R7";
    put(2, 2'b10, 13, 0); step();
    put(2, 2'b01, 13, 32'h8888_000D); step();
    put(2, 2'b11, 13, 32'h9999_000D); step();
    put(2, 2'b00, 13, 0); step();
    // R11: a write elsewhere leaves the reservation intact
    tag = "R11";
    put(0, 2'b10, 14, 0); step();
    put(1, 2'b01, 15, 32'h1212_000F); step();
    put(0, 2'b11, 14, 32'h3434_000E); step();
    // R8: contention, lowest index first, losers hold their request
    tag = "R8";
    put(0, 2'b10, 20, 0); put(1, 2'b01, 20, 32'h5656_0014); put(2, 2'b00, 20, 0); step();
    put(1, 2'b01, 20, 32'h5656_0014); put(2, 2'b00, 20, 0); step();
    put(2, 2'b00, 20, 0); step();
    put(0, 2'b11, 20, 32'h7878_0014); step();
    // R10: reset drops a live reservation
    tag = "R10";
    put(1, 2'b10, 21, 0); step();
    rst = 1'b1; step();
    rst = 1'b0;
    put(1, 2'b11, 21, 32'h9A9A_0015); step();
    // mixed random traffic on a small address window
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      for (int m = 0; m < N; m++)
        if ($urandom % 2) put(m, 2'($urandom), int'($urandom % 4), $urandom);
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule